// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block manages the retirement end of a single-thread reorder buffer. The rename side writes new entries at the tail, up to a configurable group size per cycle. The execute side marks entries complete by their buffer index. Each cycle the block retires a contiguous run of completed entries from the head, in program order. That run is capped by the commit width and ends at the first entry that is not ready.

Entries flagged non-speculative may not execute early. When such an entry becomes the oldest, the block puts its sequence number on a one-cycle release strobe so the issue logic can start it. The entry then retires once execute reports it complete.

A squash request removes every entry younger than a given sequence number. It takes several cycles and removes at most a fixed number of entries per cycle from the tail. A trap at the head waits for outstanding stores to drain, then flushes the whole buffer. A fetch-side trap stops allocation and waits for the buffer to empty. The block drives the free-entry count back to rename, with a strobe that marks each change of occupancy.

Top module: `rob_commit_ctrl`

## Requirements
- R1: Each cycle, `retire_vld` lanes 0..k-1 are high for the k oldest entries that are all complete, with k at most COMMIT_WIDTH. Retirement stops at the first incomplete entry. `retire_seq[i]` carries the sequence number of the i-th oldest entry.
- R2: While the head entry is non-speculative, not yet complete and not yet released, `release_vld` is high with `release_seq` equal to its sequence number. This happens for exactly one cycle per entry.
- R3: A non-speculative entry retires only after it has been released and marked complete. Younger entries, even complete ones, do not retire past it.
- R4: An allocation group uses lanes 0..n-1 of `alloc_vld`. Lane i is written at buffer index `alloc_idx`+i. The whole group is ignored when n exceeds the free count, or when the state is not Running or Idle. Occupancy never exceeds DEPTH.
- R5: Up to EXEC_WIDTH completion lanes per cycle mark the entries at `done_idx` complete. The mark takes effect from the next cycle.
- R6: `squash_req` latches `squash_seq`. From the next cycle the block removes, per cycle, up to SQUASH_WIDTH of the youngest entries that are younger than the target. An entry is younger when the modulo-2^SEQ_W difference (entry minus target) is nonzero with its top bit clear. `squash_done` is high in the first squash cycle that finds no such entry left. Nothing retires or allocates while squashing.
- R7: `free_cnt` equals DEPTH minus occupancy. `free_upd` is high in the cycle after any edge that changed occupancy and low otherwise. This includes cycles in which allocation and retirement cancel out.
- R8: `trap_req` in Running with a non-empty buffer enters TrapPending, where nothing retires. `trap_fire` stays low while `stores_pending` is high. It pulses in the first TrapPending cycle with `stores_pending` low, and the whole buffer is then flushed by a squash.
- R9: `ftrap_req` enters FetchTrapPending. In that state allocation is refused and retirement continues. `trap_fire` pulses in the cycle the buffer is empty, and the state then returns to Idle.
- R10: `ctrl_state` encodes Running=0, Idle=1, Squashing=2, TrapPending=3, FetchTrapPending=4. Idle is reported when the controller is in Running and the buffer is empty.
- R11: When requests arrive together, `squash_req` takes priority over `trap_req`, and `trap_req` over `ftrap_req`. Requests are accepted only in Running or Idle.
- R12: After reset the buffer is empty, `free_cnt` is DEPTH, the state is Idle and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | RENAME_WIDTH | Allocation lanes, contiguous from lane 0 |
| alloc_nonspec | input | RENAME_WIDTH | Lane entry is non-speculative |
| alloc_seq | input | RENAME_WIDTH x SEQ_W | Lane sequence numbers |
| alloc_idx | output | log2(DEPTH) | Index that lane 0 will occupy |
| done_vld | input | EXEC_WIDTH | Completion lanes |
| done_idx | input | EXEC_WIDTH x log2(DEPTH) | Indices to mark complete |
| squash_req | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Squash target; younger entries are removed |
| trap_req | input | 1 | Trap raised by the head entry |
| stores_pending | input | 1 | Stores still outstanding |
| ftrap_req | input | 1 | Fetch-side trap |
| head_vld | output | 1 | Buffer is not empty |
| head_seq | output | SEQ_W | Sequence number at the head |
| retire_vld | output | COMMIT_WIDTH | Retiring lanes this cycle |
| retire_seq | output | COMMIT_WIDTH x SEQ_W | Retiring sequence numbers |
| release_vld | output | 1 | Non-speculative head may issue |
| release_seq | output | SEQ_W | Sequence number being released |
| free_cnt | output | log2(DEPTH)+1 | Free entries |
| free_upd | output | 1 | Occupancy changed at the last edge |
| squash_done | output | 1 | Squash has finished |
| trap_fire | output | 1 | Pending trap proceeds |
| ctrl_state | output | 3 | Controller state |

## Verification
Two functions can fall in the same cycle: retirement at the head and allocation at the tail. The bench completes the last entry in the buffer and, in the cycle that entry retires, drives a one-entry allocation. It then expects `free_upd` to stay low and `free_cnt` to be unchanged, because occupancy went up by one and down by one. A scoreboard queue, filled when groups are allocated and trimmed when squashes are requested, judges every retiring lane against the program order.

// File: rtl/rob_cmt_pkg.sv
package rob_cmt_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SQUASH = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } ctl_state_e;

  // a is younger than b in a modulo-2^w sequence space
  function automatic logic seq_after(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = (a - b) << (32 - w);
    return (d != 32'd0) && !d[31];
  endfunction

  // occupancy after one cycle of allocation, retirement and squash removal
  function automatic int unsigned occ_next(input int unsigned occ, input int unsigned add,
                                           input int unsigned ret, input int unsigned rm);
    return occ + add - ret - rm;
  endfunction

endpackage

// File: rtl/rob_cmt_store.sv
module rob_cmt_store #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int RW    = 2,
  parameter int EW    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [RW-1:0]                 wr_vld,
  input  logic [IDX_W-1:0]              wr_base,
  input  logic [RW-1:0][SEQ_W-1:0]      wr_seq,
  input  logic [RW-1:0]                 wr_ns,
  input  logic [EW-1:0]                 cmp_vld,
  input  logic [EW-1:0][IDX_W-1:0]      cmp_idx,
  input  logic                          rel_set,
  input  logic [IDX_W-1:0]              rel_idx,
  output logic [DEPTH-1:0][SEQ_W-1:0]   ent_seq,
  output logic [DEPTH-1:0]              ent_ns,
  output logic [DEPTH-1:0]              ent_cmp,
  output logic [DEPTH-1:0]              ent_rel
);
  logic [RW-1:0][IDX_W-1:0] lane_idx;

  for (genvar i = 0; i < RW; i++) begin : g_lane
    assign lane_idx[i] = wr_base + IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < RW; i++) begin
        if (wr_vld[i]) ent_seq[lane_idx[i]] <= wr_seq[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_ns  <= '0;
      ent_cmp <= '0;
      ent_rel <= '0;
    end else begin
      for (int j = 0; j < EW; j++) begin
        if (cmp_vld[j]) ent_cmp[cmp_idx[j]] <= 1'b1;
      end
      if (rel_set) ent_rel[rel_idx] <= 1'b1;
      if (wr_en) begin
        for (int i = 0; i < RW; i++) begin
          if (wr_vld[i]) begin
            ent_ns[lane_idx[i]]  <= wr_ns[i];
            ent_cmp[lane_idx[i]] <= 1'b0;
            ent_rel[lane_idx[i]] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rob_cmt_window.sv
// Picks a contiguous run of qualifying entries starting at a pointer,
// walking upward (retire from head) or downward (squash from tail).
module rob_cmt_window #(
  parameter int DEPTH  = 8,
  parameter int LANES  = 2,
  parameter bit DIR_UP = 1'b1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int N_W   = $clog2(LANES + 1)
) (
  input  logic                      en,
  input  logic [IDX_W-1:0]          start,
  input  logic [CNT_W-1:0]          avail,
  input  logic [DEPTH-1:0]          ok,
  output logic [LANES-1:0][IDX_W-1:0] lane_idx,
  output logic [LANES-1:0]          take,
  output logic [N_W-1:0]            n_take
);
  for (genvar l = 0; l < LANES; l++) begin : g_idx
    if (DIR_UP) begin : g_up
      assign lane_idx[l] = start + IDX_W'(l);
    end else begin : g_dn
      assign lane_idx[l] = start - IDX_W'(l);
    end
  end

  always_comb begin
    logic run;
    run = en;
    for (int l = 0; l < LANES; l++) begin
      run = run && (CNT_W'(l) < avail) && ok[lane_idx[l]];
      take[l] = run;
    end
  end

  assign n_take = N_W'($countones(take));
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_cmt_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int SEQ_W        = 8,
  parameter int COMMIT_WIDTH = 2,
  parameter int RENAME_WIDTH = 2,
  parameter int EXEC_WIDTH   = 2,
  parameter int SQUASH_WIDTH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int RC_W  = $clog2(RENAME_WIDTH + 1),
  localparam int CC_W  = $clog2(COMMIT_WIDTH + 1),
  localparam int SC_W  = $clog2(SQUASH_WIDTH + 1)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [RENAME_WIDTH-1:0]              alloc_vld,
  input  logic [RENAME_WIDTH-1:0]              alloc_nonspec,
  input  logic [RENAME_WIDTH-1:0][SEQ_W-1:0]   alloc_seq,
  output logic [IDX_W-1:0]                     alloc_idx,
  input  logic [EXEC_WIDTH-1:0]                done_vld,
  input  logic [EXEC_WIDTH-1:0][IDX_W-1:0]     done_idx,
  input  logic                                 squash_req,
  input  logic [SEQ_W-1:0]                     squash_seq,
  input  logic                                 trap_req,
  input  logic                                 stores_pending,
  input  logic                                 ftrap_req,
  output logic                                 head_vld,
  output logic [SEQ_W-1:0]                     head_seq,
  output logic [COMMIT_WIDTH-1:0]              retire_vld,
  output logic [COMMIT_WIDTH-1:0][SEQ_W-1:0]   retire_seq,
  output logic                                 release_vld,
  output logic [SEQ_W-1:0]                     release_seq,
  output logic [CNT_W-1:0]                     free_cnt,
  output logic                                 free_upd,
  output logic                                 squash_done,
  output logic                                 trap_fire,
  output logic [2:0]                           ctrl_state
);
  ctl_state_e st_q, st_d;
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q, count_d;
  logic [SEQ_W-1:0] tgt_q, tgt_d;
  logic             all_q, all_d;
  logic             upd_q;

  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq;
  logic [DEPTH-1:0] ent_ns, ent_cmp, ent_rel;

  // named internal events
  logic [RC_W-1:0] n_alloc;
  logic            alloc_go;
  logic            retire_en;
  logic            rel_fire;
  logic [CC_W-1:0] n_ret;
  logic [SC_W-1:0] n_rm;
  logic [DEPTH-1:0] ret_ok, sq_ok;
  logic [COMMIT_WIDTH-1:0][IDX_W-1:0] ret_idx;
  logic [SQUASH_WIDTH-1:0][IDX_W-1:0] rm_idx;
  logic [SQUASH_WIDTH-1:0] rm_take;
  logic in_squash;

  assign n_alloc   = RC_W'($countones(alloc_vld));
  assign free_cnt  = CNT_W'(DEPTH) - count_q;
  assign alloc_go  = (st_q == ST_RUN) && (n_alloc != '0) && (CNT_W'(n_alloc) <= free_cnt);
  assign retire_en = ((st_q == ST_RUN) && !trap_req) || (st_q == ST_FTRAP);
  assign in_squash = (st_q == ST_SQUASH);
  assign head_vld  = (count_q != '0);
  assign head_seq  = ent_seq[head_q];
  assign alloc_idx = tail_q;

  rob_cmt_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .RW(RENAME_WIDTH), .EW(EXEC_WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_go), .wr_vld(alloc_vld), .wr_base(tail_q),
    .wr_seq(alloc_seq), .wr_ns(alloc_nonspec),
    .cmp_vld(done_vld), .cmp_idx(done_idx),
    .rel_set(rel_fire), .rel_idx(head_q),
    .ent_seq(ent_seq), .ent_ns(ent_ns), .ent_cmp(ent_cmp), .ent_rel(ent_rel)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_qual
    assign ret_ok[e] = ent_cmp[e] && (!ent_ns[e] || ent_rel[e]);
    assign sq_ok[e]  = all_q || seq_after(32'(ent_seq[e]), 32'(tgt_q), SEQ_W);
  end

  rob_cmt_window #(.DEPTH(DEPTH), .LANES(COMMIT_WIDTH), .DIR_UP(1'b1)) u_retire (
    .en(retire_en), .start(head_q), .avail(count_q), .ok(ret_ok),
    .lane_idx(ret_idx), .take(retire_vld), .n_take(n_ret)
  );

  rob_cmt_window #(.DEPTH(DEPTH), .LANES(SQUASH_WIDTH), .DIR_UP(1'b0)) u_squash (
    .en(in_squash), .start(tail_q - IDX_W'(1)), .avail(count_q), .ok(sq_ok),
    .lane_idx(rm_idx), .take(rm_take), .n_take(n_rm)
  );

  for (genvar c = 0; c < COMMIT_WIDTH; c++) begin : g_rseq
    assign retire_seq[c] = ent_seq[ret_idx[c]];
  end

  assign rel_fire    = retire_en && head_vld && ent_ns[head_q] && !ent_rel[head_q] && !ent_cmp[head_q];
  assign release_vld = rel_fire;
  assign release_seq = ent_seq[head_q];
  assign squash_done = in_squash && (n_rm == '0);
  assign trap_fire   = ((st_q == ST_TRAP) && !stores_pending) || ((st_q == ST_FTRAP) && !head_vld);
  assign ctrl_state  = ((st_q == ST_RUN) && !head_vld) ? 3'(ST_IDLE) : 3'(st_q);
  assign free_upd    = upd_q;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    all_d = all_q;
    unique case (st_q)
      ST_RUN: begin
        if (squash_req) begin
          st_d = ST_SQUASH; tgt_d = squash_seq; all_d = 1'b0;
        end else if (trap_req && head_vld) begin
          st_d = ST_TRAP;
        end else if (ftrap_req) begin
          st_d = ST_FTRAP;
        end
      end
      ST_SQUASH: if (n_rm == '0) st_d = ST_RUN;
      ST_TRAP:   if (!stores_pending) begin st_d = ST_SQUASH; all_d = 1'b1; end
      ST_FTRAP:  if (!head_vld) st_d = ST_RUN;
      default:   st_d = ST_RUN;
    endcase
  end

  assign count_d = CNT_W'(occ_next(int'(count_q), alloc_go ? int'(n_alloc) : 0,
                                   int'(n_ret), int'(n_rm)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      tgt_q   <= '0;
      all_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      all_q   <= all_d;
      head_q  <= head_q + IDX_W'(n_ret);
      tail_q  <= tail_q + (alloc_go ? IDX_W'(n_alloc) : '0) - IDX_W'(n_rm);
      count_q <= count_d;
      upd_q   <= (count_d != count_q);
    end
  end

  // R4: occupancy bounded by the buffer depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R1: lane 0 only retires a completed head
  p_retire_complete_r1: assert property (@(posedge clk) disable iff (!rst_n)
    retire_vld[0] |-> ent_cmp[head_q]);

  // R2: a release is not repeated for the same entry
  p_release_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    release_vld |=> (!release_vld || (release_seq != $past(release_seq))));

  // R3: a non-speculative head retires only after its release
  p_ns_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld[0] && ent_ns[head_q]) |-> ent_rel[head_q]);

  // R6: squash removes a bounded number per cycle and never grows occupancy
  p_squash_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_squash |=> ((CNT_W+1)'(count_q) + (CNT_W+1)'(SQUASH_WIDTH) >= (CNT_W+1)'($past(count_q))));
  p_squash_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_squash |=> (count_q <= $past(count_q)));

  // R7: without the strobe the free count holds
  p_free_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !free_upd |-> $stable(free_cnt));

  // R8: a trap never proceeds while stores are outstanding
  p_trap_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_TRAP) && stores_pending) |-> !trap_fire);

  // R10: Idle only with an empty buffer
  p_idle_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == 3'(ST_IDLE)) |-> (free_cnt == CNT_W'(DEPTH)));
endmodule

// File: tb/rob_commit_ctrl_bench.sv
module rob_commit_ctrl_bench;
  localparam int DEPTH = 8, SEQ_W = 8, CW = 2, RW = 2, EW = 2, SW = 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] alloc_vld = '0, alloc_nonspec = '0;
  logic [RW-1:0][SEQ_W-1:0] alloc_seq = '0;
  logic [IDX_W-1:0] alloc_idx;
  logic [EW-1:0] done_vld = '0;
  logic [EW-1:0][IDX_W-1:0] done_idx = '0;
  logic squash_req = 0, trap_req = 0, stores_pending = 0, ftrap_req = 0;
  logic [SEQ_W-1:0] squash_seq = '0;
  logic head_vld, release_vld, free_upd, squash_done, trap_fire;
  logic [SEQ_W-1:0] head_seq, release_seq;
  logic [CW-1:0] retire_vld;
  logic [CW-1:0][SEQ_W-1:0] retire_seq;
  logic [IDX_W:0] free_cnt;
  logic [2:0] ctrl_state;

  rob_commit_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .COMMIT_WIDTH(CW), .RENAME_WIDTH(RW),
                    .EXEC_WIDTH(EW), .SQUASH_WIDTH(SW)) u_rob_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_nonspec(alloc_nonspec),
    .alloc_seq(alloc_seq), .alloc_idx(alloc_idx), .done_vld(done_vld), .done_idx(done_idx),
    .squash_req(squash_req), .squash_seq(squash_seq), .trap_req(trap_req),
    .stores_pending(stores_pending), .ftrap_req(ftrap_req), .head_vld(head_vld),
    .head_seq(head_seq), .retire_vld(retire_vld), .retire_seq(retire_seq),
    .release_vld(release_vld), .release_seq(release_seq), .free_cnt(free_cnt),
    .free_upd(free_upd), .squash_done(squash_done), .trap_fire(trap_fire),
    .ctrl_state(ctrl_state)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, retired_total = 0;
  int exp_q[$];
  int idx_of[256];
  bit finished = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit younger(input int a, input int t);
    int d;
    d = (a - t) & 255;
    return (d != 0) && (d < 128);
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // driver: one allocation group; the model decides acceptance from free space
  task automatic alloc_grp(input int n, input int s0, input logic [RW-1:0] ns);
    bit acc;
    acc = (n <= DEPTH - exp_q.size());
    for (int i = 0; i < RW; i++) begin
      alloc_vld[i]     = (i < n);
      alloc_nonspec[i] = ns[i];
      alloc_seq[i]     = SEQ_W'((s0 + i) & 255);
      if (i < n && acc) begin
        idx_of[(s0 + i) & 255] = (int'(alloc_idx) + i) % DEPTH;
        exp_q.push_back((s0 + i) & 255);
      end
    end
    cyc();
    alloc_vld = '0; alloc_nonspec = '0;
  endtask

  task automatic mark(input int a, input int b);
    done_vld = '0;
    if (a >= 0) begin done_vld[0] = 1'b1; done_idx[0] = IDX_W'(a); end
    if (b >= 0) begin done_vld[1] = 1'b1; done_idx[1] = IDX_W'(b); end
    cyc();
    done_vld = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) cyc();
    chk_eq("R1 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic trim(input int tgt);
    while (exp_q.size() != 0 && younger(exp_q[$], tgt)) void'(exp_q.pop_back());
  endtask

  task automatic do_squash(input int tgt, input int k);
    int n;
    squash_req = 1'b1; squash_seq = SEQ_W'(tgt);
    trim(tgt);
    cyc();
    squash_req = 1'b0;
    n = 1;
    while (!squash_done && n < 50) begin cyc(); n++; end
    chk_eq("R6 squash_done cycle", n, (k + SW - 1) / SW + 1);
    cyc();
  endtask

  // monitor: every retiring lane is judged against program order
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        for (int i = 0; i < CW; i++) begin
          if (retire_vld[i]) begin
            if (exp_q.size() == 0) chk_eq("R1 retire with empty scoreboard", int'(retire_seq[i]), -1);
            else chk_eq("R1 retire order", int'(retire_seq[i]), exp_q.pop_front());
            retired_total++;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R12 reset state
    chk_eq("R12 free_cnt", int'(free_cnt), DEPTH);
    chk_eq("R12 state idle", int'(ctrl_state), 1);
    chk_eq("R12 strobes", int'({free_upd, release_vld, retire_vld, squash_done, trap_fire}), 0);

    // R4, R7, R10: allocation
    alloc_grp(2, 1, 2'b00);
    chk_eq("R7 free after alloc", int'(free_cnt), 6);
    chk_eq("R7 free_upd after alloc", int'(free_upd), 1);
    chk_eq("R10 running", int'(ctrl_state), 0);
    cyc();
    chk_eq("R7 free_upd quiet", int'(free_upd), 0);
    alloc_grp(2, 3, 2'b00);

    // R1, R5: in-order retirement, stop at incomplete head
    mark(idx_of[2], -1);
    chk_eq("R1 no retire past incomplete head", int'(retire_vld), 0);
    mark(idx_of[1], idx_of[3]);
    chk_eq("R5 two completions, R1 two lanes", int'(retire_vld), 3);
    cyc();
    chk_eq("R1 single lane", int'(retire_vld), 1);
    cyc();
    chk_eq("R1 stop at seq 4", int'(retire_vld), 0);
    chk_eq("R1 retired count", retired_total, 3);

    // R7: retire and allocate in the same cycle
    mark(idx_of[4], -1);
    chk_eq("R1 retire seq 4", int'(retire_vld), 1);
    alloc_grp(1, 5, 2'b00);
    chk_eq("R7 balanced no strobe", int'(free_upd), 0);
    chk_eq("R7 balanced free", int'(free_cnt), 7);
    mark(idx_of[5], -1);
    cyc();
    chk_eq("R10 idle when empty", int'(ctrl_state), 1);

    // R2, R3: non-speculative head
    alloc_grp(2, 10, 2'b01);
    chk_eq("R2 release strobe", int'(release_vld), 1);
    chk_eq("R2 release seq", int'(release_seq), 10);
    chk_eq("R2 head seq", int'(head_seq), 10);
    mark(idx_of[11], -1);
    chk_eq("R2 released once", int'(release_vld), 0);
    chk_eq("R3 younger waits", int'(retire_vld), 0);
    mark(idx_of[10], -1);
    chk_eq("R3 retire after release", int'(retire_vld), 3);
    cyc();

    // R4: fill, then overflow attempt ignored
    for (int k = 0; k < 4; k++) alloc_grp(2, 20 + 2 * k, 2'b00);
    chk_eq("R4 full", int'(free_cnt), 0);
    alloc_grp(2, 28, 2'b00);
    chk_eq("R4 overflow ignored", int'(free_cnt), 0);
    chk_eq("R4 overflow no strobe", int'(free_upd), 0);

    // R6: multi-cycle squash of 5 entries
    squash_req = 1'b1; squash_seq = 8'd22;
    trim(22);
    cyc();
    squash_req = 1'b0;
    chk_eq("R10 squashing", int'(ctrl_state), 2);
    alloc_vld = 2'b01; alloc_seq[0] = 8'd99;
    cyc();
    alloc_vld = '0;
    chk_eq("R6 rate free", int'(free_cnt), 2);
    chk_eq("R6 not done early", int'(squash_done), 0);
    cyc();
    chk_eq("R6 rate free 2", int'(free_cnt), 4);
    cyc();
    chk_eq("R6 done", int'(squash_done), 1);
    cyc();
    chk_eq("R6 back to running", int'(ctrl_state), 0);
    chk_eq("R4 alloc in squash ignored", int'(free_cnt), 5);
    mark(idx_of[20], idx_of[21]);
    mark(idx_of[22], -1);
    drain();

    // R6: wrap-around sequence numbers
    alloc_grp(2, 254, 2'b00);
    alloc_grp(2, 0, 2'b00);
    do_squash(255, 2);
    chk_eq("R6 wrap survivors", int'(free_cnt), 6);
    mark(idx_of[254], idx_of[255]);
    drain();

    // R8: trap waits for stores, then flushes
    alloc_grp(2, 40, 2'b00);
    trap_req = 1'b1; stores_pending = 1'b1;
    cyc();
    trap_req = 1'b0;
    chk_eq("R8 trap pending", int'(ctrl_state), 3);
    mark(idx_of[40], idx_of[41]);
    chk_eq("R8 no retire while pending", int'(retire_vld), 0);
    chk_eq("R8 no fire with stores", int'(trap_fire), 0);
    cyc();
    stores_pending = 1'b0;
    #1;
    chk_eq("R8 fire after stores drain", int'(trap_fire), 1);
    exp_q.delete();
    cyc();
    chk_eq("R8 flush squashing", int'(ctrl_state), 2);
    for (int k = 0; k < 10 && !squash_done; k++) cyc();
    cyc();
    chk_eq("R8 flushed empty", int'(free_cnt), DEPTH);
    chk_eq("R8 idle after flush", int'(ctrl_state), 1);

    // R11: squash beats trap
    alloc_grp(2, 50, 2'b00);
    squash_req = 1'b1; squash_seq = 8'd51; trap_req = 1'b1; stores_pending = 1'b1;
    cyc();
    squash_req = 1'b0; trap_req = 1'b0; stores_pending = 1'b0;
    chk_eq("R11 squash priority", int'(ctrl_state), 2);
    chk_eq("R6 nothing younger done", int'(squash_done), 1);
    cyc();

    // R9, R11: fetch trap
    ftrap_req = 1'b1;
    cyc();
    ftrap_req = 1'b0;
    chk_eq("R9 fetch trap pending", int'(ctrl_state), 4);
    alloc_vld = 2'b01; alloc_seq[0] = 8'd60; squash_req = 1'b1; squash_seq = 8'd50;
    cyc();
    alloc_vld = '0; squash_req = 1'b0;
    chk_eq("R11 squash ignored in fetch trap", int'(ctrl_state), 4);
    chk_eq("R9 alloc refused", int'(free_cnt), 6);
    mark(idx_of[50], idx_of[51]);
    chk_eq("R9 retire continues", int'(retire_vld), 3);
    chk_eq("R9 no fire while occupied", int'(trap_fire), 0);
    cyc();
    chk_eq("R9 fire when empty", int'(trap_fire), 1);
    cyc();
    chk_eq("R9 idle after fetch trap", int'(ctrl_state), 1);
    chk_eq("R1 scoreboard empty", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule